// File: doc/BRIEF.md
# Keyed Write-Protection Controller

This block sits between a serial slave's byte-write port and a 256-byte storage array. It decides, in the same cycle, whether a write request reaches the storage (`commit_o`) or is dropped. Three sets of bytes in the address space are not plain storage. A configuration byte picks which address regions are guarded. A pair of key bytes switches the guard on or off. Two setting bytes drive a pair of potentiometer wiper codes.

A hardware write-protect input overrides everything. While it is high, no write commits and no internal state moves. While it is low, the software lock alone decides. The lock guards the regions selected by the configuration byte only while the lock is on. Writes to the top three addresses are discarded.

Top module: `keyed_wprot`

## Requirements
- R1: While `wp_i` is 1, `commit_o` stays 0 and no write changes the lock state, the configuration or either wiper output.
- R2: After reset, `locked_o` is 0, the configuration is 000b, both wiper outputs are 0, and `commit_o` is 0.
- R3: A permitted write to an address from 00h to F9h raises `commit_o` in the same cycle as `wr_en_i`.
- R4: Address FAh holds the region configuration, and only data bits 2:0 are kept. Bit 0 guards 00h–7Fh, bit 1 guards 80h–F7h and bit 2 guards F8h–FFh. A guarded write is dropped only while `locked_o` is 1.
- R5: When the byte stored at FBh equals 56h and the byte stored at FCh equals 25h, `locked_o` becomes 1 in the cycle after the second key write. The two keys may be written in either order.
- R6: When the byte stored at FBh equals 67h and the byte stored at FCh equals 36h, `locked_o` becomes 0 in the cycle after the second key write.
- R7: A key write that leaves FBh/FCh holding anything other than one of the two full pairs leaves `locked_o` unchanged.
- R8: While locked with configuration bit 2 set, writes to FAh, FBh and FCh are dropped, so the unlock pair has no effect.
- R9: Writes to FDh, FEh and FFh never raise `commit_o` and change no state.
- R10: `wiper1_o` holds the last permitted byte written to F8h, starting from the cycle after that write.
- R11: `wiper0_o` takes bits 6:0 of the last permitted byte written to F9h, limited to at most 99 (63h).
- R12: Writes to FAh, FBh and FCh are held inside the block and never raise `commit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| wp_i | input | 1 | Hardware write protect; 1 blocks all writes |
| wr_en_i | input | 1 | Write request strobe, one cycle per byte |
| wr_addr_i | input | 8 | Write request address |
| wr_data_i | input | 8 | Write request data |
| commit_o | output | 1 | Write may proceed to storage (same cycle) |
| locked_o | output | 1 | Software lock is on |
| wiper0_o | output | 7 | 100-position wiper code, 0 to 99 |
| wiper1_o | output | 8 | 256-position wiper code |

## Verification
The gating decision is tested against every region configuration. Each is tried with the lock both off and on, and with probes at the low, middle and top regions. This separates a wrong region decode from a wrong lock qualifier.

Key sequences are sent in both orders. Mixed pairs show that the lock needs a full pair and not a single byte. Relocking with bit 2 set confirms that the key bytes are guarded by the upper page.

Wiper bytes of 05h, 63h, 64h, 85h and E3h separate a missing MSB drop from a missing clamp. Repeating the key and setting writes under `wp_i` shows that the hardware input freezes all state and does not merely mask `commit_o`.

// File: rtl/keyed_wprot.sv
module keyed_wprot #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int W0_MAX = 99,
  parameter logic [DW-1:0] LOCK_A = 8'h56,
  parameter logic [DW-1:0] LOCK_B = 8'h25,
  parameter logic [DW-1:0] OPEN_A = 8'h67,
  parameter logic [DW-1:0] OPEN_B = 8'h36
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          wp_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          commit_o,
  output logic          locked_o,
  output logic [DW-2:0] wiper0_o,
  output logic [DW-1:0] wiper1_o
);
  localparam logic [AW-1:0] MID_LO = AW'(1 << (AW - 1));
  localparam logic [AW-1:0] TOP_LO = {AW{1'b1}} - AW'(7);
  localparam logic [AW-1:0] SET1_A = TOP_LO;
  localparam logic [AW-1:0] SET0_A = TOP_LO + AW'(1);
  localparam logic [AW-1:0] CFG_A  = TOP_LO + AW'(2);
  localparam logic [AW-1:0] KEYA_A = TOP_LO + AW'(3);
  localparam logic [AW-1:0] KEYB_A = TOP_LO + AW'(4);

  logic [2:0]    cfg_q;
  logic          lock_q;
  logic [DW-1:0] key_a_q, key_b_q, w1_q;
  logic [DW-2:0] w0_q;

  wire in_low = wr_addr_i < MID_LO;
  wire in_top = wr_addr_i >= TOP_LO;
  wire in_mid = !in_low && !in_top;
  wire guarded = lock_q && ((in_low && cfg_q[0]) || (in_mid && cfg_q[1]) || (in_top && cfg_q[2]));
  wire take = wr_en_i && !wp_i && !guarded;

  wire [DW-1:0] key_a_n = (take && wr_addr_i == KEYA_A) ? wr_data_i : key_a_q;
  wire [DW-1:0] key_b_n = (take && wr_addr_i == KEYB_A) ? wr_data_i : key_b_q;
  wire          key_wr  = take && (wr_addr_i == KEYA_A || wr_addr_i == KEYB_A);
  wire [DW-2:0] w0_raw  = wr_data_i[DW-2:0];
  wire [DW-2:0] w0_clip = (w0_raw > (DW-1)'(W0_MAX)) ? (DW-1)'(W0_MAX) : w0_raw;

  assign commit_o = take && (wr_addr_i <= SET0_A);
  assign locked_o = lock_q;
  assign wiper0_o = w0_q;
  assign wiper1_o = w1_q;

  always_ff @(posedge clk_i) begin
    if (!rst_n_i) begin
      cfg_q   <= '0;
      lock_q  <= 1'b0;
      key_a_q <= '0;
      key_b_q <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
    end else begin
      key_a_q <= key_a_n;
      key_b_q <= key_b_n;
      if (take && wr_addr_i == CFG_A)  cfg_q <= wr_data_i[2:0];
      if (take && wr_addr_i == SET1_A) w1_q  <= wr_data_i;
      if (take && wr_addr_i == SET0_A) w0_q  <= w0_clip;
      if (key_wr) begin
        if (key_a_n == LOCK_A && key_b_n == LOCK_B)      lock_q <= 1'b1;
        else if (key_a_n == OPEN_A && key_b_n == OPEN_B) lock_q <= 1'b0;
      end
    end
  end

  // R1
  wp_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wp_i |=> $stable(locked_o) && $stable(wiper0_o) && $stable(wiper1_o));
  // R1
  wp_nocommit_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wp_i |-> !commit_o);
  // R9
  reserved_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_addr_i > KEYB_A) |-> !commit_o ##1 ($stable(locked_o) && $stable(wiper0_o) && $stable(wiper1_o)));
  // R11
  wiper0_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wiper0_o <= (DW-1)'(W0_MAX));
  // R5
  lock_source_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(locked_o) |-> $past(wr_en_i && !wp_i));
  // R4
  low_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (locked_o && cfg_q[0] && wr_addr_i < MID_LO) |-> !commit_o);
endmodule

// File: tb/keyed_wprot_tb_top.sv
module keyed_wprot_tb_top;
  logic clk = 0, rst_n = 0, wp = 0, wr_en = 0;
  logic [7:0] addr = 0, data = 0;
  logic commit, locked;
  logic [6:0] w0;
  logic [7:0] w1;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keyed_wprot dut_i (.clk_i(clk), .rst_n_i(rst_n), .wp_i(wp), .wr_en_i(wr_en),
    .wr_addr_i(addr), .wr_data_i(data), .commit_o(commit), .locked_o(locked),
    .wiper0_o(w0), .wiper1_o(w1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit exp_c, input string req);
    @(negedge clk);
    addr = a; data = d; wr_en = 1;
    #1 chk(commit == exp_c, req, commit, exp_c);
    @(posedge clk);
    #1 wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; wp = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(locked == 0 && w0 == 0 && w1 == 0 && commit == 0, "R2", {locked, w0, w1}, 0);
    @(negedge clk) rst_n = 1;
  endtask

  task automatic t_open();
    wr(8'h00, 8'h11, 1, "R3 low open");
    wr(8'hF7, 8'h11, 1, "R3 mid open");
    wr(8'hFA, 8'h07, 0, "R12 cfg no commit");
    wr(8'h10, 8'h11, 1, "R4 cfg inactive while unlocked");
  endtask

  task automatic t_lock_all();
    wr(8'hFA, 8'h07, 0, "R12");
    wr(8'hFC, 8'h25, 0, "R12 key b");
    chk(locked == 0, "R7 one key only", locked, 0);
    wr(8'hFB, 8'h56, 0, "R12 key a");
    chk(locked == 1, "R5 lock reverse order", locked, 1);
    wr(8'h00, 8'h01, 0, "R4 low guarded");
    wr(8'h80, 8'h01, 0, "R4 mid guarded");
    wr(8'hF8, 8'h44, 0, "R4 top guarded");
    chk(w1 == 0, "R8 wiper held", w1, 0);
    wr(8'hFB, 8'h67, 0, "R8");
    wr(8'hFC, 8'h36, 0, "R8");
    chk(locked == 1, "R8 unlock ignored", locked, 1);
  endtask

  task automatic t_low_only();
    wr(8'hFA, 8'hF9, 0, "R12");
    wr(8'hFB, 8'h56, 0, "R12");
    wr(8'hFC, 8'h25, 0, "R12");
    chk(locked == 1, "R5 lock", locked, 1);
    wr(8'h7F, 8'h01, 0, "R4 low guarded bit0");
    wr(8'h85, 8'h01, 1, "R4 upper cfg bits dropped, mid open");
    wr(8'hF8, 8'hA5, 1, "R4 top open");
    chk(w1 == 8'hA5, "R10 wiper1", w1, 8'hA5);
    wr(8'hFB, 8'h67, 0, "R12");
    chk(locked == 1, "R7 mixed pair", locked, 1);
    wr(8'hFC, 8'h36, 0, "R12");
    chk(locked == 0, "R6 unlock", locked, 0);
    wr(8'h10, 8'h01, 1, "R6 low open again");
  endtask

  task automatic t_mid_only();
    wr(8'hFA, 8'h02, 0, "R12");
    wr(8'hFB, 8'h56, 0, "R12");
    wr(8'hFC, 8'h36, 0, "R12");
    chk(locked == 0, "R7 mismatched pair", locked, 0);
    wr(8'hFC, 8'h25, 0, "R12");
    chk(locked == 1, "R5", locked, 1);
    wr(8'h10, 8'h01, 1, "R4 low open");
    wr(8'hC0, 8'h01, 0, "R4 mid guarded bit1");
    wr(8'hF9, 8'h05, 1, "R4 top open");
    chk(w0 == 5, "R11 plain", w0, 5);
  endtask

  task automatic t_wiper0();
    wr(8'hF9, 8'h63, 1, "R11"); chk(w0 == 99, "R11 max", w0, 99);
    wr(8'hF9, 8'h64, 1, "R11"); chk(w0 == 99, "R11 clamp", w0, 99);
    wr(8'hF9, 8'h85, 1, "R11"); chk(w0 == 5, "R11 msb dropped", w0, 5);
    wr(8'hF9, 8'hE3, 1, "R11"); chk(w0 == 99, "R11 msb dropped max", w0, 99);
    wr(8'hF8, 8'hFF, 1, "R10"); chk(w1 == 8'hFF, "R10 full", w1, 8'hFF);
  endtask

  task automatic t_reserved();
    wr(8'hFB, 8'h56, 0, "R12");
    for (int a = 253; a <= 255; a++) begin
      wr(8'(a), 8'h25, 0, "R9 no commit");
      chk(locked == 0, "R9 lock unchanged", locked, 0);
    end
    wr(8'hFC, 8'h25, 0, "R12");
    chk(locked == 1, "R5 after reserved", locked, 1);
  endtask

  task automatic t_wp();
    wr(8'hF8, 8'h12, 1, "R10");
    wp = 1;
    wr(8'h00, 8'h01, 0, "R1 low");
    wr(8'hF8, 8'h34, 0, "R1 wiper1");
    wr(8'hF9, 8'h07, 0, "R1 wiper0");
    chk(w1 == 8'h12 && w0 == 0, "R1 wipers frozen", {w0, w1}, 8'h12);
    wr(8'hFB, 8'h56, 0, "R1");
    wr(8'hFC, 8'h25, 0, "R1");
    chk(locked == 0, "R1 no lock", locked, 0);
    wp = 0;
    wr(8'hFC, 8'h00, 0, "R12");
    wr(8'hFB, 8'h00, 0, "R12");
    chk(locked == 0, "R1 keys not stored under wp", locked, 0);
  endtask

  initial begin
    do_reset(); t_open();
    do_reset(); t_lock_all();
    do_reset(); t_low_only();
    do_reset(); t_mid_only();
    do_reset(); t_wiper0();
    do_reset(); t_reserved();
    do_reset(); t_wp();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule